// File: doc/BRIEF.md
# 16-bit Rotate Unit with Carry

This block rotates a 16-bit operand in one of four ways: a plain rotate left or right, or a rotate left or right through the carry flag. A rotate through carry treats the carry and the operand as one 17-bit ring. Each request carries the operand, an 8-bit count, a 2-bit operation select and the incoming carry.

One cycle after a valid request, the block presents the rotated data and the new carry and overflow flags, marked by a single valid strobe. Two enables come with them. One tells the register file whether the data must be written back. The other tells the flag logic whether carry and overflow change. No other flag is ever produced.

Counts follow the usual processor rules. A plain rotate looks only at the low five count bits and rotates by that value modulo 16. A through-carry rotate reduces the low five bits modulo 17. A count that reduces to zero leaves the data and the flags untouched. The exception is a plain rotate by a nonzero multiple of 16: it leaves the data as it is but still updates the flags.

Top module: `rot_carry_unit`

## Requirements
- R1: `out_valid` is high exactly one cycle after each cycle with `in_valid` high. When the previous cycle had `in_valid` low, both `result_we` and `flags_we` are low.
- R2: For a plain rotate (`op_sel` 00 or 01) whose count has its low five bits all zero (for example 0 or 32):
  - `result` equals the operand.
  - `result_we` and `flags_we` are low.
  - `carry_out` echoes `carry_in` and `ovf_out` is 0.
- R3: For a plain rotate whose low five count bits equal 16:
  - `result` equals the operand and `result_we` is low.
  - `flags_we` is high.
  - The flags are computed from the unchanged operand by the rule of R4 or R5.
- R4: `op_sel` 00 rotates left by (count mod 32) mod 16. After it, `carry_out` is result bit 0 and `ovf_out` is result bit 0 XOR result bit 15.
- R5: `op_sel` 01 rotates right by (count mod 32) mod 16. After it, `carry_out` is result bit 15 and `ovf_out` is result bit 15 XOR result bit 14.
- R6: For `op_sel` 10 and 11 the effective count is (count mod 32) mod 17. When it is zero (for example 0, 17 or 49):
  - `result` equals the operand.
  - Both enables are low.
  - `carry_out` echoes `carry_in` and `ovf_out` is 0.
- R7: `op_sel` 10 rotates the 17-bit value {carry_in, operand} left by n. The new carry is operand bit (16-n) and `ovf_out` is the new carry XOR result bit 15. For n=1 the result is (operand<<1)|carry_in, and for n=16 it is (carry_in<<15)|(operand>>1).
- R8: `op_sel` 11 rotates {carry_in, operand} right by n. `carry_in` lands at result bit (16-n), the new carry is operand bit (n-1), and `ovf_out` is result bit 15 XOR result bit 14.
- R9: A nonzero effective rotate raises both `result_we` and `flags_we`.
- R10: While reset is high, every output is driven to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| operand | input | 16 | Data to rotate |
| count | input | 8 | Rotate count |
| op_sel | input | 2 | 00 left, 01 right, 10 left through carry, 11 right through carry |
| carry_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Registered outputs are valid |
| result | output | 16 | Rotated data |
| result_we | output | 1 | Data must be written back |
| flags_we | output | 1 | Carry and overflow must be updated |
| carry_out | output | 1 | New carry flag |
| ovf_out | output | 1 | New overflow flag |

## Verification
The bench builds the block with its default parameters: 16-bit data, an 8-bit count and a 5-bit count mask. The 8-bit count reaches values above 31, which shows that the upper bits are discarded before any modulo is taken. It also reaches 17, 34 and 49, which separate the modulo-17 reduction used by the through-carry rotates from the modulo-16 reduction used by the plain ones. Expected values come from a one-bit-at-a-time rotation model. That model shares no shift arithmetic with the design.

// File: rtl/rot_pkg.sv
package rot_pkg;
  typedef enum logic [1:0] {
    ROT_L  = 2'b00,
    ROT_R  = 2'b01,
    ROT_LC = 2'b10,
    ROT_RC = 2'b11
  } rot_op_e;
endpackage

// File: rtl/rot_amount.sv
// Reduces the raw count to the effective rotate distance for the selected mode.
module rot_amount #(
  parameter int W      = 16,
  parameter int CNT_W  = 8,
  parameter int MASK_W = 5,
  localparam int AMT_W = $clog2(W + 1),
  localparam int LOG_W = $clog2(W)
) (
  input  logic [CNT_W-1:0] count,
  input  logic             thru,
  output logic [AMT_W-1:0] amt,
  output logic             any_cnt
);
  logic [MASK_W-1:0] masked;
  logic [MASK_W-1:0] mod_ring;
  logic              unused_hi;

  assign masked    = count[MASK_W-1:0];
  assign unused_hi = ^count[CNT_W-1:MASK_W];
  assign any_cnt   = |masked;
  assign mod_ring  = masked % MASK_W'(W + 1);

  always_comb begin
    if (thru) amt = AMT_W'(mod_ring);
    else      amt = AMT_W'(masked[LOG_W-1:0]);
  end
endmodule

// File: rtl/rot_datapath.sv
// Combinational rotate network and flag derivation.
module rot_datapath
  import rot_pkg::*;
#(
  parameter int W      = 16,
  localparam int AMT_W = $clog2(W + 1),
  localparam int XW    = W + 1
) (
  input  rot_op_e          op,
  input  logic [W-1:0]     operand,
  input  logic             cin,
  input  logic [AMT_W-1:0] amt,
  output logic [W-1:0]     res,
  output logic             cf,
  output logic             of
);
  logic [W-1:0]  res_l, res_r;
  logic [XW-1:0] ring, ring_l, ring_r;

  assign ring   = {cin, operand};
  assign res_l  = W'(({operand, operand} << amt) >> W);
  assign res_r  = W'({operand, operand} >> amt);
  assign ring_l = XW'(({ring, ring} << amt) >> XW);
  assign ring_r = XW'({ring, ring} >> amt);

  always_comb begin
    unique case (op)
      ROT_L: begin
        res = res_l;
        cf  = res_l[0];
        of  = res_l[0] ^ res_l[W-1];
      end
      ROT_R: begin
        res = res_r;
        cf  = res_r[W-1];
        of  = res_r[W-1] ^ res_r[W-2];
      end
      ROT_LC: begin
        res = ring_l[W-1:0];
        cf  = ring_l[W];
        of  = ring_l[W] ^ ring_l[W-1];
      end
      default: begin
        res = ring_r[W-1:0];
        cf  = ring_r[W];
        of  = ring_r[W-1] ^ ring_r[W-2];
      end
    endcase
  end
endmodule

// File: rtl/rot_carry_unit.sv
module rot_carry_unit
  import rot_pkg::*;
#(
  parameter int W      = 16,
  parameter int CNT_W  = 8,
  parameter int MASK_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [W-1:0]     operand,
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       op_sel,
  input  logic             carry_in,
  output logic             out_valid,
  output logic [W-1:0]     result,
  output logic             result_we,
  output logic             flags_we,
  output logic             carry_out,
  output logic             ovf_out
);
  localparam int AMT_W = $clog2(W + 1);

  rot_op_e          op;
  logic [AMT_W-1:0] amt;
  logic             any_cnt;
  logic [W-1:0]     res_n;
  logic             cf_n, of_n;
  logic             rwe_n, fwe_n;

  assign op = rot_op_e'(op_sel);

  rot_amount #(.W(W), .CNT_W(CNT_W), .MASK_W(MASK_W)) u_amt (
    .count   (count),
    .thru    (op_sel[1]),
    .amt     (amt),
    .any_cnt (any_cnt)
  );

  rot_datapath #(.W(W)) u_dp (
    .op      (op),
    .operand (operand),
    .cin     (carry_in),
    .amt     (amt),
    .res     (res_n),
    .cf      (cf_n),
    .of      (of_n)
  );

  assign rwe_n = |amt;
  assign fwe_n = op_sel[1] ? (|amt) : any_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      result_we <= 1'b0;
      flags_we  <= 1'b0;
      carry_out <= 1'b0;
      ovf_out   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      result_we <= in_valid & rwe_n;
      flags_we  <= in_valid & fwe_n;
      if (in_valid) begin
        result    <= res_n;
        carry_out <= fwe_n ? cf_n : carry_in;
        ovf_out   <= fwe_n & of_n;
      end
    end
  end
endmodule

// File: rtl/rot_carry_unit_chk.sv
module rot_carry_unit_chk #(
  parameter int W      = 16,
  parameter int CNT_W  = 8,
  parameter int MASK_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [W-1:0]     operand,
  input logic [CNT_W-1:0] count,
  input logic [1:0]       op_sel,
  input logic             out_valid,
  input logic [W-1:0]     result,
  input logic             result_we,
  input logic             flags_we,
  input logic             carry_out,
  input logic             ovf_out
);
  logic [MASK_W-1:0] m;
  logic              ring_zero;
  logic              unused_hi;

  assign m         = count[MASK_W-1:0];
  assign ring_zero = (m % MASK_W'(W + 1)) == '0;
  assign unused_hi = ^count[CNT_W-1:MASK_W];

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !result_we && !flags_we)); // R1
  AST_PLAIN_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_sel[1] && m == '0) |=>
      (!result_we && !flags_we && !ovf_out && result == $past(operand))); // R2
  AST_PLAIN_SIXTEEN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_sel[1] && m == MASK_W'(W)) |=>
      (!result_we && flags_we && result == $past(operand))); // R3
  AST_LEFT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b00 && m != '0) |=>
      (carry_out == result[0] && ovf_out == (result[0] ^ result[W-1]))); // R4
  AST_RIGHT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b01 && m != '0) |=>
      (carry_out == result[W-1] && ovf_out == (result[W-1] ^ result[W-2]))); // R5
  AST_RING_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel[1] && ring_zero) |=>
      (!result_we && !flags_we && result == $past(operand))); // R6
  AST_RCR_OVF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b11 && !ring_zero) |=>
      (ovf_out == (result[W-1] ^ result[W-2]))); // R8
  AST_RING_WE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel[1] && !ring_zero) |=> (result_we && flags_we)); // R9
  AST_WRITE_HAS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    result_we |-> (flags_we && out_valid)); // R9
endmodule

bind rot_carry_unit rot_carry_unit_chk #(.W(W), .CNT_W(CNT_W), .MASK_W(MASK_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .operand   (operand),
  .count     (count),
  .op_sel    (op_sel),
  .out_valid (out_valid),
  .result    (result),
  .result_we (result_we),
  .flags_we  (flags_we),
  .carry_out (carry_out),
  .ovf_out   (ovf_out)
);

// File: tb/rot_carry_unit_tb.sv
module rot_carry_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] operand = '0;
  logic [7:0]  count = '0;
  logic [1:0]  op_sel = '0;
  logic        carry_in = 1'b0;
  logic        out_valid, result_we, flags_we, carry_out, ovf_out;
  logic [15:0] result;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  rot_carry_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
    .count(count), .op_sel(op_sel), .carry_in(carry_in),
    .out_valid(out_valid), .result(result), .result_we(result_we),
    .flags_we(flags_we), .carry_out(carry_out), .ovf_out(ovf_out)
  );

  // Bit-serial reference model
  task automatic model(input logic [1:0] op, input logic [7:0] cnt,
                       input logic [15:0] d, input logic ci,
                       output logic [15:0] r, output logic rwe, output logic fwe,
                       output logic co, output logic ov);
    int m;
    int n;
    logic c;
    m = cnt & 31;
    r = d;
    c = ci;
    if (op[1] == 1'b0) begin
      n = m % 16;
      for (int k = 0; k < n; k++) begin
        if (op[0] == 1'b0) r = {r[14:0], r[15]};
        else               r = {r[0], r[15:1]};
      end
      rwe = (n != 0);
      fwe = (m != 0);
      if (!fwe) begin
        co = ci; ov = 1'b0;
      end else if (op[0] == 1'b0) begin
        co = r[0]; ov = r[0] ^ r[15];
      end else begin
        co = r[15]; ov = r[15] ^ r[14];
      end
    end else begin
      n = m % 17;
      for (int k = 0; k < n; k++) begin
        logic nc;
        if (op[0] == 1'b0) begin
          nc = r[15]; r = {r[14:0], c}; c = nc;
        end else begin
          nc = r[0]; r = {c, r[15:1]}; c = nc;
        end
      end
      rwe = (n != 0);
      fwe = (n != 0);
      if (!fwe) begin
        co = ci; ov = 1'b0;
      end else begin
        co = c;
        ov = (op[0] == 1'b0) ? (c ^ r[15]) : (r[15] ^ r[14]);
      end
    end
  endtask

  task automatic check(input string req, input logic [15:0] er, input logic ev,
                       input logic erwe, input logic efwe, input logic eco,
                       input logic eov);
    n_checks++;
    if (out_valid !== ev || result !== er || result_we !== erwe ||
        flags_we !== efwe || carry_out !== eco || ovf_out !== eov) begin
      n_fail++;
      $display("FAIL %s: got v=%b r=%h rwe=%b fwe=%b c=%b o=%b exp v=%b r=%h rwe=%b fwe=%b c=%b o=%b",
               req, out_valid, result, result_we, flags_we, carry_out, ovf_out,
               ev, er, erwe, efwe, eco, eov);
    end
  endtask

  task automatic run_op(input string req, input logic [1:0] op,
                        input logic [7:0] cnt, input logic [15:0] d,
                        input logic ci);
    logic [15:0] er;
    logic erwe, efwe, eco, eov;
    model(op, cnt, d, ci, er, erwe, efwe, eco, eov);
    @(negedge clk);
    op_sel = op; count = cnt; operand = d; carry_in = ci; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, er, 1'b1, erwe, efwe, eco, eov);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 reset", 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_rol();
    run_op("R4 rol 1", 2'b00, 8'd1, 16'h8001, 1'b0);
    run_op("R4 rol 4", 2'b00, 8'd4, 16'h1234, 1'b1);
    run_op("R4 rol 15", 2'b00, 8'd15, 16'hC003, 1'b0);
    run_op("R4 rol 19", 2'b00, 8'd19, 16'hA5F0, 1'b0);
    run_op("R4 rol 227 masked", 2'b00, 8'd227, 16'h4001, 1'b1);
  endtask

  task automatic t_ror();
    run_op("R5 ror 1", 2'b01, 8'd1, 16'h0001, 1'b0);
    run_op("R5 ror 7", 2'b01, 8'd7, 16'hBEEF, 1'b0);
    run_op("R5 ror 31", 2'b01, 8'd31, 16'h6001, 1'b1);
  endtask

  task automatic t_plain_zero();
    run_op("R2 rol 0", 2'b00, 8'd0, 16'h1357, 1'b1);
    run_op("R2 ror 32", 2'b01, 8'd32, 16'h8642, 1'b0);
  endtask

  task automatic t_sixteen();
    run_op("R3 rol 16", 2'b00, 8'd16, 16'h8001, 1'b0);
    run_op("R3 ror 48", 2'b01, 8'd48, 16'h4000, 1'b1);
  endtask

  task automatic t_rcl();
    run_op("R7 rcl 1", 2'b10, 8'd1, 16'h8000, 1'b1);
    run_op("R7 rcl 16", 2'b10, 8'd16, 16'h0003, 1'b1);
    run_op("R7 rcl 5", 2'b10, 8'd5, 16'h0C35, 1'b0);
    run_op("R9 rcl 34 masked", 2'b10, 8'd34, 16'hF00F, 1'b1);
  endtask

  task automatic t_rcr();
    run_op("R8 rcr 1", 2'b11, 8'd1, 16'h0001, 1'b1);
    run_op("R8 rcr 16", 2'b11, 8'd16, 16'h8000, 1'b0);
    run_op("R8 rcr 9", 2'b11, 8'd9, 16'h5A3C, 1'b1);
  endtask

  task automatic t_ring_zero();
    run_op("R6 rcl 0", 2'b10, 8'd0, 16'h2468, 1'b1);
    run_op("R6 rcr 17", 2'b11, 8'd17, 16'h9ABC, 1'b1);
    run_op("R6 rcl 49", 2'b10, 8'd49, 16'h7777, 1'b0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    check("R1 idle", result, 1'b0, 1'b0, 1'b0, carry_out, ovf_out);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_rol();
        t_idle();
        t_ror();
        t_plain_zero();
        t_sixteen();
        t_rcl();
        t_rcr();
        t_ring_zero();
        t_idle();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_checks++;
          n_fail++;
          $display("FAIL R1 watchdog: got running exp finished");
        end
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule